// File: doc/BRIEF.md
# Thresholded Interrupt Priority Selector

This block picks the one interrupt source that a single target context should service next. Each source has a pending bit, an in-service (claimed) bit, a per-context enable bit and a small priority value. The context has a threshold. A source takes part only when it is pending, enabled and not in service. Its priority must also be strictly above the threshold. Among those sources the highest priority wins. When priorities are equal, the lowest source number wins.

The result is the winning source number, with 0 meaning "nothing to take", and a level request line for the context. Internally the sources are split into 32-bit words. Each word picks a local winner in one pipeline stage, and the word winners are merged in a second stage. Every result is therefore a pure function of the inputs presented two rising edges earlier, and it holds steady while the inputs hold steady. The number of sources and the priority width are parameters. The source count need not be a multiple of 32; the unused bit positions in the last word are tied off inside the block.

Top module: `irq_prio_sel`

## Requirements
- R1: A source is considered only if its pending bit is 1, its claimed bit is 0 and its enable bit is 1. A source missing any of these is never output.
- R2: A considered source qualifies only if its priority is strictly greater than `threshold_i`. A priority equal to the threshold is masked.
- R3: Among qualifying sources with the same highest priority, the smallest source number is output.
- R4: `id_o` is 0 when no source qualifies. Source 0 is never output, whatever its pending, enable and priority inputs are.
- R5: `irq_o` is 1 exactly when `id_o` is nonzero.
- R6: `id_o` is always below `NUM_SRC`. With a source count that is not a multiple of 32, the highest source still works, and the padding positions never win.
- R7: The result for inputs held across a rising edge appears at the output after the second rising edge. The output is unchanged after only the first edge.
- R8: While `rst_n` is 0, `id_o` is 0 and `irq_o` is 0.
- R9: The highest qualifying priority wins regardless of which 32-bit word holds it; a higher-numbered word's source beats a lower-priority source in word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pending_i | input | NUM_SRC | Pending bit per source; bit i is source i |
| claimed_i | input | NUM_SRC | In-service bit per source |
| enable_i | input | NUM_SRC | Enable bit per source for this context |
| prio_i | input | NUM_SRC*PRIO_W | Priority of source i in bits [i*PRIO_W +: PRIO_W] |
| threshold_i | input | PRIO_W | Context threshold |
| id_o | output | $clog2(NUM_SRC) | Winning source number, 0 when none |
| irq_o | output | 1 | Interrupt request level for the context |

## Verification
Both outputs are due two rising edges after the input change that causes them. The first edge loads the per-word winners, and the second loads the merged result. The bench drives inputs on a falling edge and waits two rising edges. It then samples 1 ns later. For R7 it also samples after the first edge, to confirm the old value is still present. A second instance with 40 sources covers the partial final word. Random rounds compare both instances against a scan model written independently in the bench.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  // Sources handled by one first-stage picker
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WORD_IDX_W = $clog2(WORD_W);
endpackage

// File: rtl/irq_word_pick.sv
// Picks the best qualifying source inside one word (combinational).
module irq_word_pick #(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0]        elig_i,
  input  logic [WORD_W*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]        thr_i,
  output logic                     hit_o,
  output logic [PRIO_W-1:0]        prio_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;
  logic              found;

  // Ascending scan with a strict compare: ties keep the lower index,
  // and starting from the threshold masks priorities equal to it.
  always_comb begin
    best_p = thr_i;
    best_i = '0;
    found  = 1'b0;
    for (int j = 0; j < WORD_W; j++) begin
      if (elig_i[j] && (prio_i[j*PRIO_W +: PRIO_W] > best_p)) begin
        best_p = prio_i[j*PRIO_W +: PRIO_W];
        best_i = IDX_W'(j);
        found  = 1'b1;
      end
    end
  end

  assign hit_o  = found;
  assign prio_o = best_p;
  assign idx_o  = best_i;
endmodule

// File: rtl/irq_word_merge.sv
// Merges the per-word winners into one source number (combinational).
module irq_word_merge #(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ID_W      = 6,
  localparam int unsigned IDX_W    = $clog2(WORD_W)
) (
  input  logic [NUM_WORDS-1:0]        hit_i,
  input  logic [NUM_WORDS*PRIO_W-1:0] prio_i,
  input  logic [NUM_WORDS*IDX_W-1:0]  idx_i,
  output logic                        found_o,
  output logic [ID_W-1:0]             id_o
);
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;
  logic              found;

  always_comb begin
    best_p  = '0;
    best_id = '0;
    found   = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (hit_i[w] && (!found || (prio_i[w*PRIO_W +: PRIO_W] > best_p))) begin
        best_p  = prio_i[w*PRIO_W +: PRIO_W];
        best_id = ID_W'(w * WORD_W + int'(idx_i[w*IDX_W +: IDX_W]));
        found   = 1'b1;
      end
    end
  end

  assign found_o = found;
  assign id_o    = best_id;
endmodule

// File: rtl/irq_prio_sel.sv
// Two-stage thresholded interrupt selector for one target context.
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pending_i,
  input  logic [NUM_SRC-1:0]        claimed_i,
  input  logic [NUM_SRC-1:0]        enable_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         threshold_i,
  output logic [ID_W-1:0]           id_o,
  output logic                      irq_o
);
  localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_SRC   = NUM_WORDS * WORD_W;

  // Padded eligibility and priority; positions past NUM_SRC stay zero
  logic [PAD_SRC-1:0]        elig_pad;
  logic [PAD_SRC*PRIO_W-1:0] prio_pad;

  always_comb begin
    elig_pad = '0;
    prio_pad = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      elig_pad[i] = pending_i[i] & ~claimed_i[i] & enable_i[i];
    end
    prio_pad[NUM_SRC*PRIO_W-1:0] = prio_i;
  end

  // Stage 1: one picker per word
  logic [NUM_WORDS-1:0]            hit_d, hit_q;
  logic [NUM_WORDS*PRIO_W-1:0]     wprio_d, wprio_q;
  logic [NUM_WORDS*WORD_IDX_W-1:0] widx_d, widx_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    irq_word_pick #(
      .PRIO_W (PRIO_W),
      .WORD_W (WORD_W)
    ) u_pick (
      .elig_i (elig_pad[w*WORD_W +: WORD_W]),
      .prio_i (prio_pad[w*WORD_W*PRIO_W +: WORD_W*PRIO_W]),
      .thr_i  (threshold_i),
      .hit_o  (hit_d[w]),
      .prio_o (wprio_d[w*PRIO_W +: PRIO_W]),
      .idx_o  (widx_d[w*WORD_IDX_W +: WORD_IDX_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      wprio_q <= '0;
      widx_q  <= '0;
    end else begin
      hit_q   <= hit_d;
      wprio_q <= wprio_d;
      widx_q  <= widx_d;
    end
  end

  // Stage 2: merge word winners
  logic            found_d;
  logic [ID_W-1:0] id_d;

  irq_word_merge #(
    .NUM_WORDS (NUM_WORDS),
    .PRIO_W    (PRIO_W),
    .WORD_W    (WORD_W),
    .ID_W      (ID_W)
  ) u_merge (
    .hit_i   (hit_q),
    .prio_i  (wprio_q),
    .idx_i   (widx_q),
    .found_o (found_d),
    .id_o    (id_d)
  );

  logic [ID_W-1:0] id_q;
  logic            irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      irq_q <= found_d;
    end
  end

  assign id_o  = id_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        pending_i,
  input logic [NUM_SRC-1:0]        claimed_i,
  input logic [NUM_SRC-1:0]        enable_i,
  input logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input logic [PRIO_W-1:0]         threshold_i,
  input logic [ID_W-1:0]           id_o,
  input logic                      irq_o
);
  // Inputs delayed by the block's two-edge latency
  logic [NUM_SRC-1:0]        elig_d1, elig_d2;
  logic [NUM_SRC*PRIO_W-1:0] prio_d1, prio_d2;
  logic [PRIO_W-1:0]         thr_d1, thr_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_d1 <= '0;
      elig_d2 <= '0;
      prio_d1 <= '0;
      prio_d2 <= '0;
      thr_d1  <= '0;
      thr_d2  <= '0;
    end else begin
      elig_d1 <= pending_i & ~claimed_i & enable_i;
      elig_d2 <= elig_d1;
      prio_d1 <= prio_i;
      prio_d2 <= prio_d1;
      thr_d1  <= threshold_i;
      thr_d2  <= thr_d1;
    end
  end

  logic              win_elig;
  logic [PRIO_W-1:0] win_prio;
  logic              any_elig;

  always_comb begin
    win_elig = 1'b0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(id_o) == i) begin
        win_elig = elig_d2[i];
        win_prio = prio_d2[i*PRIO_W +: PRIO_W];
      end
    end
    any_elig = |elig_d2[NUM_SRC-1:1];
  end

  assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_o != '0) |-> win_elig);

  assert_winner_above_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_o != '0) |-> (win_prio > thr_d2));

  assert_none_gives_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |-> (id_o == '0));

  assert_irq_tracks_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (id_o != '0));

  assert_id_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(id_o) < NUM_SRC);
endmodule

bind irq_prio_sel irq_prio_sel_chk #(
  .NUM_SRC (NUM_SRC),
  .PRIO_W  (PRIO_W),
  .ID_W    (ID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pending_i   (pending_i),
  .claimed_i   (claimed_i),
  .enable_i    (enable_i),
  .prio_i      (prio_i),
  .threshold_i (threshold_i),
  .id_o        (id_o),
  .irq_o       (irq_o)
);

// File: tb/irq_prio_sel_tb.sv
`timescale 1ns/1ps
module irq_prio_sel_tb;
  localparam int NS  = 64;
  localparam int NSO = 40;
  localparam int PW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NS-1:0]    pend, clm, en;
  logic [NS*PW-1:0] pr;
  logic [PW-1:0]    thr;
  logic [5:0] id_a, id_b;
  logic       irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  irq_prio_sel #(.NUM_SRC(NS), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pending_i(pend), .claimed_i(clm),
    .enable_i(en), .prio_i(pr), .threshold_i(thr), .id_o(id_a), .irq_o(irq_a));

  irq_prio_sel #(.NUM_SRC(NSO), .PRIO_W(PW)) u_dut_odd (
    .clk(clk), .rst_n(rst_n), .pending_i(pend[NSO-1:0]), .claimed_i(clm[NSO-1:0]),
    .enable_i(en[NSO-1:0]), .prio_i(pr[NSO*PW-1:0]), .threshold_i(thr),
    .id_o(id_b), .irq_o(irq_b));

  function automatic int ref_pick(int n);
    int best = int'(thr);
    int id = 0;
    for (int i = 1; i < n; i++) begin
      if (pend[i] && !clm[i] && en[i] && int'(pr[i*PW +: PW]) > best) begin
        best = int'(pr[i*PW +: PW]);
        id = i;
      end
    end
    return id;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_in();
    pend = '0; clm = '0; en = '0; pr = '0; thr = '0;
  endtask

  task automatic make_src(int i, int p);
    pend[i] = 1'b1; en[i] = 1'b1; clm[i] = 1'b0; pr[i*PW +: PW] = PW'(p);
  endtask

  // inputs already set at a falling edge; wait two rising edges, sample after
  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    clear_in(); make_src(7, 5);
    @(posedge clk); @(posedge clk); #1;
    check("R8 id in reset", int'(id_a), 0);
    check("R8 irq in reset", int'(irq_a), 0);
    @(negedge clk); rst_n = 1'b1;
    settle();
  endtask

  task automatic t_latency();
    @(negedge clk); clear_in(); settle();
    @(negedge clk); make_src(12, 4);
    @(posedge clk); #1;
    check("R7 unchanged after one edge", int'(id_a), 0);
    @(posedge clk); #1;
    check("R7 due after two edges", int'(id_a), 12);
    check("R5 irq with nonzero id", int'(irq_a), 1);
    @(negedge clk); @(negedge clk);
    check("R7 stable while inputs hold", int'(id_a), 12);
  endtask

  task automatic t_gating();
    @(negedge clk); clear_in(); make_src(20, 6); clm[20] = 1'b1; settle();
    check("R1 claimed source skipped", int'(id_a), 0);
    check("R5 irq low with id 0", int'(irq_a), 0);
    @(negedge clk); clm[20] = 1'b0; en[20] = 1'b0; settle();
    check("R1 disabled source skipped", int'(id_a), 0);
    @(negedge clk); en[20] = 1'b1; pend[20] = 1'b0; settle();
    check("R1 idle source skipped", int'(id_a), 0);
    @(negedge clk); pend[20] = 1'b1; settle();
    check("R1 full qualifying source", int'(id_a), 20);
  endtask

  task automatic t_threshold();
    @(negedge clk); clear_in(); thr = 3'd4; make_src(9, 4); settle();
    check("R2 equal to threshold masked", int'(id_a), 0);
    @(negedge clk); pr[9*PW +: PW] = 3'd5; settle();
    check("R2 one above threshold wins", int'(id_a), 9);
    @(negedge clk); thr = 3'd7; settle();
    check("R2 top threshold masks all", int'(id_a), 0);
  endtask

  task automatic t_tie();
    @(negedge clk); clear_in(); make_src(40, 3); make_src(9, 3); make_src(5, 3);
    make_src(2, 1); settle();
    check("R3 tie goes to lowest", int'(id_a), 5);
    @(negedge clk); clear_in(); make_src(33, 6); make_src(60, 6); settle();
    check("R3 tie inside upper word", int'(id_a), 33);
  endtask

  task automatic t_cross();
    @(negedge clk); clear_in(); make_src(3, 2); make_src(50, 6); settle();
    check("R9 upper word higher priority", int'(id_a), 50);
    @(negedge clk); pr[3*PW +: PW] = 3'd7; settle();
    check("R9 lower word higher priority", int'(id_a), 3);
  endtask

  task automatic t_src0();
    @(negedge clk); clear_in(); make_src(0, 7); settle();
    check("R4 source 0 never output", int'(id_a), 0);
    check("R4 source 0 raises no irq", int'(irq_a), 0);
  endtask

  task automatic t_odd();
    @(negedge clk); clear_in(); make_src(39, 1); settle();
    check("R6 last source of partial word", int'(id_b), 39);
    @(negedge clk); make_src(32, 1); settle();
    check("R6 partial word tie", int'(id_b), 32);
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      pend = {$urandom, $urandom};
      clm  = {$urandom, $urandom} & {$urandom, $urandom};
      en   = {$urandom, $urandom} | {$urandom, $urandom};
      for (int i = 0; i < NS; i++) pr[i*PW +: PW] = PW'($urandom);
      thr = PW'($urandom_range(0, 5));
      if (k % 7 == 0) pend = pend & {$urandom, $urandom} & {$urandom, $urandom};
      settle();
      check("R1 R2 R3 random 64", int'(id_a), ref_pick(NS));
      check("R5 random irq", int'(irq_a), int'(ref_pick(NS) != 0));
      check("R6 random 40", int'(id_b), ref_pick(NSO));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_in();
    t_reset();
    t_latency();
    t_gating();
    t_threshold();
    t_tie();
    t_cross();
    t_src0();
    t_odd();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule